// File: doc/BRIEF.md
# Configuration space enumeration and BAR sizing sequencer

This block is a host-side hardware walker for PCI configuration space. After a start pulse it runs the whole enumeration through a simple register-access port that reaches two host registers: a configuration address register and a configuration data register. First it clears the address register. It then probes every device slot in turn by reading the identification word. A slot counts as populated when that read returns anything other than all ones.

For each populated slot, the sequencer sizes the first two base address registers before it moves on to the next slot. It writes all ones to each one, reads it back, decides from bit 0 whether the register maps memory or I/O space, masks the low attribute bits, then inverts the result and adds one. The presence bitmap is held on an output. The size and type of each base address register go into a small result memory that the user reads through a one-cycle-latency port. A one-cycle done pulse marks the end of the run.

The block only walks and sizes. It does not assign base addresses. It has no connection to the electrical bus: the access port is served by a host bridge, or by a behavioural target in the bench.

Top module: `cfg_enum_seq`

## Requirements
- R1: After start, the first access is a write of 0x0000_0000 to the address register (acc_sel=0, acc_we=1).
- R2: The sequencer probes slots 0 to NUM_SLOTS-1 (default 20) in ascending order. Each probe writes the address register with the device number in bits 15:11 and byte offset 0x00 in bits 7:0, with all other bits zero, and then reads the data register (acc_sel=1, acc_we=0).
- R3: present[i] is set when the probe read of slot i returns any value other than 0xFFFF_FFFF, including 0xFFFF_FFFE. present is cleared at start and holds its value between runs.
- R4: To size a base address register, the sequencer writes the address register with the slot and offset 0x10 (first BAR) or 0x14 (second BAR). It then writes 0xFFFF_FFFF to the data register and after that reads the data register.
- R5: Read-back bit 0 selects the type: 0 for memory and 1 for I/O. A memory value has bits 3:0 cleared and an I/O value has bits 1:0 cleared. The size is the bitwise NOT of the masked value plus one, and it is reported with res_io equal to bit 0.
- R6: A read-back of zero gives a size of zero, reported as memory type.
- R7: For every populated slot, the first BAR is sized before the second. Unpopulated slots get no BAR accesses.
- R8: Only one access is outstanding at a time. acc_req, acc_we, acc_sel and acc_wdata hold steady until acc_ack, and acc_req drops in the cycle after acc_ack.
- R9: busy is high from the cycle after start until done. done is high for exactly one cycle at the end, and a start that arrives while busy is ignored.
- R10: The size and type for slot res_slot and BAR res_bar appear on res_size and res_io one cycle after they are presented. They are valid for populated slots after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| present | output | NUM_SLOTS | Populated-slot bitmap |
| acc_req | output | 1 | Access request, held until acknowledge |
| acc_we | output | 1 | 1 = write, 0 = read |
| acc_sel | output | 1 | 0 = address register, 1 = data register |
| acc_wdata | output | 32 | Write data |
| acc_ack | input | 1 | Access acknowledge |
| acc_rdata | input | 32 | Read data, valid with acc_ack |
| res_slot | input | 5 | Result read slot |
| res_bar | input | 1 | Result read BAR index |
| res_size | output | 32 | Size requested by the selected BAR |
| res_io | output | 1 | Selected BAR is I/O type |

## Verification
The assertions assume that acc_ack rises only while acc_req is high and lasts a single cycle per request, and that acc_rdata is valid in the acknowledge cycle. The behavioural target in the bench acknowledges exactly one cycle after it sees a fresh request and registers its read data in that same edge, so it never acknowledges an idle port. Start pulses last one cycle. One of them is issued deliberately in the middle of a run to exercise the rule that it is ignored.

// File: rtl/cfg_enum_pkg.sv
package cfg_enum_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_PROBE_A, S_PROBE_R,
    S_BAR_A, S_BAR_W, S_BAR_R, S_BAR_ST, S_NEXT
  } seq_state_t;

  localparam int DATA_W    = 32;
  localparam int DEV_LSB   = 11;
  localparam logic [7:0] OFS_ID   = 8'h00;
  localparam logic [7:0] OFS_BAR0 = 8'h10;
  localparam logic [7:0] OFS_BAR1 = 8'h14;
endpackage

// File: rtl/cfg_bar_calc.sv
module cfg_bar_calc #(
  parameter int W = 32
) (
  input  logic [W-1:0] readback,
  output logic [W-1:0] size,
  output logic         is_io
);
  logic [W-1:0] masked;
  always_comb begin
    is_io  = readback[0];
    masked = readback;
    if (is_io) masked[1:0] = 2'b00;
    else       masked[3:0] = 4'b0000;
    size   = ~masked + {{(W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/cfg_result_ram.sv
module cfg_result_ram #(
  parameter int DEPTH = 40,
  parameter int W     = 33,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cfg_enum_seq.sv
module cfg_enum_seq
  import cfg_enum_pkg::*;
#(
  parameter int NUM_SLOTS = 20,
  localparam int DEV_W    = $clog2(NUM_SLOTS),
  localparam int RAM_D    = 2 ** (DEV_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic [NUM_SLOTS-1:0] present,
  output logic                 acc_req,
  output logic                 acc_we,
  output logic                 acc_sel,
  output logic [DATA_W-1:0]    acc_wdata,
  input  logic                 acc_ack,
  input  logic [DATA_W-1:0]    acc_rdata,
  input  logic [DEV_W-1:0]     res_slot,
  input  logic                 res_bar,
  output logic [DATA_W-1:0]    res_size,
  output logic                 res_io
);
  localparam logic [DEV_W-1:0] LAST = DEV_W'(NUM_SLOTS - 1);
  localparam logic [DATA_W-1:0] ONES = '1;

  seq_state_t        state;
  logic [DEV_W-1:0]  dev;
  logic              bar;
  logic [DATA_W-1:0] rb_q;

  logic              plan_we, plan_sel, is_acc;
  logic [DATA_W-1:0] plan_wd, addr_word;

  always_comb begin
    addr_word = '0;
    addr_word[DEV_LSB +: DEV_W] = dev;
    if (state == S_PROBE_A) addr_word[7:0] = OFS_ID;
    else                    addr_word[7:0] = bar ? OFS_BAR1 : OFS_BAR0;
  end

  always_comb begin
    is_acc   = 1'b1;
    plan_we  = 1'b1;
    plan_sel = 1'b0;
    plan_wd  = '0;
    case (state)
      S_CLR:     plan_wd = '0;
      S_PROBE_A: plan_wd = addr_word;
      S_BAR_A:   plan_wd = addr_word;
      S_BAR_W:   begin plan_sel = 1'b1; plan_wd = ONES; end
      S_PROBE_R, S_BAR_R: begin plan_sel = 1'b1; plan_we = 1'b0; end
      default:   is_acc = 1'b0;
    endcase
  end

  logic [DATA_W-1:0] calc_size;
  logic              calc_io;
  cfg_bar_calc #(.W(DATA_W)) calc_i (
    .readback(rb_q), .size(calc_size), .is_io(calc_io)
  );

  logic [DATA_W:0] rd_word;
  cfg_result_ram #(.DEPTH(RAM_D), .W(DATA_W + 1)) ram_i (
    .clk(clk),
    .wr_en(state == S_BAR_ST),
    .wr_addr({dev, bar}),
    .wr_data({calc_io, calc_size}),
    .rd_addr({res_slot, res_bar}),
    .rd_data(rd_word)
  );
  assign res_size = rd_word[DATA_W-1:0];
  assign res_io   = rd_word[DATA_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      dev       <= '0;
      bar       <= 1'b0;
      rb_q      <= '0;
      present   <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      acc_req   <= 1'b0;
      acc_we    <= 1'b0;
      acc_sel   <= 1'b0;
      acc_wdata <= '0;
    end else begin
      done <= 1'b0;
      if (is_acc) begin
        if (!acc_req) begin
          acc_req   <= 1'b1;
          acc_we    <= plan_we;
          acc_sel   <= plan_sel;
          acc_wdata <= plan_wd;
        end else if (acc_ack) begin
          acc_req <= 1'b0;
          case (state)
            S_CLR:     state <= S_PROBE_A;
            S_PROBE_A: state <= S_PROBE_R;
            S_PROBE_R: begin
              if (acc_rdata != ONES) begin
                present[dev] <= 1'b1;
                bar   <= 1'b0;
                state <= S_BAR_A;
              end else begin
                state <= S_NEXT;
              end
            end
            S_BAR_A:   state <= S_BAR_W;
            S_BAR_W:   state <= S_BAR_R;
            S_BAR_R:   begin rb_q <= acc_rdata; state <= S_BAR_ST; end
            default:   state <= S_IDLE;
          endcase
        end
      end else begin
        case (state)
          S_IDLE: if (start) begin
            busy    <= 1'b1;
            present <= '0;
            dev     <= '0;
            bar     <= 1'b0;
            state   <= S_CLR;
          end
          S_BAR_ST: begin
            if (!bar) begin bar <= 1'b1; state <= S_BAR_A; end
            else      state <= S_NEXT;
          end
          S_NEXT: begin
            if (dev == LAST) begin
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= S_IDLE;
            end else begin
              dev   <= dev + 1'b1;
              state <= S_PROBE_A;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_enum_seq_chk.sv
module cfg_enum_seq_chk #(
  parameter int NUM_SLOTS = 20
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic [NUM_SLOTS-1:0] present,
  input logic                 acc_req,
  input logic                 acc_we,
  input logic                 acc_sel,
  input logic [31:0]          acc_wdata,
  input logic                 acc_ack
);
  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    acc_req && !acc_ack |=> acc_req && $stable(acc_we) && $stable(acc_sel) && $stable(acc_wdata));

  a_r8_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    acc_req && acc_ack |=> !acc_req);

  a_r8_req_only_busy: assert property (@(posedge clk) disable iff (rst)
    acc_req |-> busy);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    busy && !done |=> busy || done);

  a_r3_present_held_idle: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> $stable(present));
endmodule

bind cfg_enum_seq cfg_enum_seq_chk #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .present(present), .acc_req(acc_req), .acc_we(acc_we), .acc_sel(acc_sel),
  .acc_wdata(acc_wdata), .acc_ack(acc_ack)
);

// File: tb/cfg_enum_seq_tb.sv
module cfg_enum_seq_tb_top;
  localparam int NS = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        busy, done;
  logic [NS-1:0] present;
  logic        acc_req, acc_we, acc_sel;
  logic [31:0] acc_wdata;
  logic        acc_ack = 1'b0;
  logic [31:0] acc_rdata = '0;
  logic [4:0]  res_slot = '0;
  logic        res_bar = 1'b0;
  logic [31:0] res_size;
  logic        res_io;

  always #4 clk = ~clk;

  cfg_enum_seq #(.NUM_SLOTS(NS)) dut_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .present(present), .acc_req(acc_req), .acc_we(acc_we), .acc_sel(acc_sel),
    .acc_wdata(acc_wdata), .acc_ack(acc_ack), .acc_rdata(acc_rdata),
    .res_slot(res_slot), .res_bar(res_bar), .res_size(res_size), .res_io(res_io)
  );

  int n_total = 0, n_fail = 0;
  int cur_run = 0;
  bit [31:0] cur_pat = '0;
  int addr_wr_cnt, probe_cnt, proto_err, bar_rd_cnt;
  logic [31:0] first_addr, areg;
  bit armed [32][2];
  bit bar0_rd [32];
  int done_cnt = 0, wide_err = 0;
  logic prev_done = 1'b0;
  int cyc_total = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int kind_of(int run, int s, int b);
    return (s * 3 + b + run) % 4;
  endfunction

  function automatic logic [31:0] exp_size(int run, int s, int b);
    case (kind_of(run, s, b))
      0: return 32'h0;
      1: return 32'h1 << (4 + s % 20);
      2: return 32'h1 << (2 + s % 8);
      default: return 32'h0010_0000;
    endcase
  endfunction

  function automatic bit exp_io(int run, int s, int b);
    return kind_of(run, s, b) == 2;
  endfunction

  function automatic logic [31:0] rb_of(int run, int s, int b);
    logic [31:0] sz;
    sz = exp_size(run, s, b);
    case (kind_of(run, s, b))
      0: return 32'h0;
      1: return ~(sz - 1) | 32'h8;
      2: return ~(sz - 1) | 32'h1;
      default: return 32'hFFF0_0004;
    endcase
  endfunction

  function automatic logic [31:0] id_of(int s);
    if (!cur_pat[s]) return 32'hFFFF_FFFF;
    if (cur_run == 1 && s == 5) return 32'hFFFF_FFFE;
    return {16'h0100 + 16'(s), 16'h1AB0};
  endfunction

  // behavioural configuration target
  always @(posedge clk) begin
    if (rst) begin
      acc_ack <= 1'b0;
      acc_rdata <= '0;
    end else begin
      acc_ack <= 1'b0;
      if (acc_req && !acc_ack) begin
        int d, b;
        acc_ack <= 1'b1;
        d = int'(areg[15:11]);
        b = (areg[7:0] == 8'h14) ? 1 : 0;
        if (acc_we && !acc_sel) begin
          if (addr_wr_cnt == 0) first_addr = acc_wdata;
          addr_wr_cnt++;
          areg = acc_wdata;
        end else if (acc_we) begin
          if ((areg[7:0] == 8'h10 || areg[7:0] == 8'h14) && acc_wdata == 32'hFFFF_FFFF)
            armed[d][b] = 1'b1;
        end else if (areg[7:0] == 8'h00 && areg[31:16] == 0 && areg[10:8] == 0) begin
          if (d != probe_cnt) proto_err++;
          probe_cnt++;
          acc_rdata <= id_of(d);
        end else if (areg[7:0] == 8'h10 || areg[7:0] == 8'h14) begin
          bar_rd_cnt++;
          if (!cur_pat[d]) proto_err++;
          if (b == 1 && !bar0_rd[d]) proto_err++;
          if (b == 0) bar0_rd[d] = 1'b1;
          if (!armed[d][b]) begin
            proto_err++;
            acc_rdata <= 32'h0;
          end else begin
            acc_rdata <= rb_of(cur_run, d, b);
          end
          armed[d][b] = 1'b0;
        end else begin
          proto_err++;
          acc_rdata <= 32'h0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && done) begin
      done_cnt++;
      if (prev_done) wide_err++;
    end
    prev_done = done;
    cyc_total++;
    if (cyc_total > 150000) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc_total);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  task automatic run_case(input int run, input bit [31:0] pat, input bit poke);
    int pop;
    bit seen_busy;
    pop = 0;
    seen_busy = 1'b0;
    cur_run = run;
    cur_pat = pat & 32'h000F_FFFF;
    addr_wr_cnt = 0; probe_cnt = 0; proto_err = 0; bar_rd_cnt = 0;
    first_addr = 32'hDEAD_BEEF; areg = '0;
    for (int s = 0; s < 32; s++) begin
      armed[s][0] = 1'b0; armed[s][1] = 1'b0; bar0_rd[s] = 1'b0;
    end
    done_cnt = 0; wide_err = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      if (busy) seen_busy = 1'b1;
      if (done_cnt > 0) break;
      start = (poke && c == 30);
      @(negedge clk);
    end
    start = 1'b0;
    repeat (20) @(negedge clk);
    for (int s = 0; s < NS; s++) pop += cur_pat[s];
    chk(seen_busy, "R9", "busy during run", 32'(seen_busy), 32'h1);
    chk(done_cnt == 1 && !busy, "R9", "single done and idle after", done_cnt, 32'h1);
    chk(wide_err == 0, "R9", "done one cycle", wide_err, 32'h0);
    chk(first_addr == 32'h0, "R1", "first address write", first_addr, 32'h0);
    chk(probe_cnt == NS, "R2", "probe count", probe_cnt, NS);
    chk(proto_err == 0, "R4", "sizing protocol/order errors (R7)", proto_err, 32'h0);
    chk(bar_rd_cnt == 2 * pop, "R7", "bar reads only on populated slots", bar_rd_cnt, 2 * pop);
    chk(32'(present) == cur_pat, "R3", "presence map", 32'(present), cur_pat);
    for (int s = 0; s < NS; s++) begin
      if (cur_pat[s]) begin
        for (int b = 0; b < 2; b++) begin
          res_slot = 5'(s);
          res_bar  = b[0];
          @(negedge clk);
          if (kind_of(run, s, b) == 0)
            chk(res_size == 0 && !res_io, "R6", "zero readback size", res_size, 32'h0);
          else
            chk(res_size == exp_size(run, s, b), "R5", "bar size", res_size, exp_size(run, s, b));
          chk(res_io == exp_io(run, s, b), "R10", "bar type", 32'(res_io), 32'(exp_io(run, s, b)));
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !acc_req, "R9", "reset outputs", {busy, done, acc_req}, 32'h0);
    chk(present == '0, "R3", "reset presence", 32'(present), 32'h0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!acc_req, "R8", "no request while idle", 32'(acc_req), 32'h0);
    run_case(0, 32'h0000_0000, 1'b0);
    run_case(1, 32'hFFFF_FFFF, 1'b1);
    run_case(2, 32'h0005_5555, 1'b0);
    run_case(3, 32'h0008_0000, 1'b0);
    run_case(4, 32'h0000_0401, 1'b0);
    run_case(5, 32'h000A_AAAA, 1'b0);
    // presence holds between runs
    repeat (10) @(negedge clk);
    chk(32'(present) == 32'h000A_AAAA, "R3", "presence held idle", 32'(present), 32'h000A_AAAA);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule